// File: doc/BRIEF.md
# Two-Context Stall-Switched Issue Selector

This block sits in front of one shared execution pipeline and holds two hardware thread contexts, A and B. Each context owns a full private copy of the general-purpose register file. All other resources are shared: the caches, the predictors, the front end and the execution units. In any cycle one context is the active one. Its register file feeds the two read ports, and its ready operation is the one that issues.

The active context changes only on a long-latency event. This is never on a timer. A cache miss parks the missing thread until memory reports completion. A branch mispredict gives up the pipeline for one switch but parks nothing. A parked thread takes the pipeline back when its completion arrives. If both threads are parked, nothing issues and an idle flag is raised. When the two threads then wake together, the one that ran least recently goes first.

With dual issue enabled, the inactive thread may issue alongside the active one in the same cycle. This is allowed only when one operation is integer and the other is floating point.

The controller is a three-state machine:
- States: `S_RUN_A`, `S_RUN_B` and `S_IDLE`.
- Transitions:
  - switch: run to the other run state on a stall of the active thread.
  - return: run to the other run state when the parked thread's memory completes.
  - park: run to idle when both threads are parked.
  - wake: idle to a run state.

Top module: `thread_ctx_sel`

## Requirements

Thread and context index 0 is A and index 1 is B. `act_ctx` reads 0 for A and 1 for B. An operation class bit of 0 means integer and 1 means floating point.

- R1: After reset, `act_ctx` is 0 and `idle` is 0. Every register of both contexts reads 0.
- R2: A cache miss on the active thread sets it pending. While a thread is pending it never issues.
  - The missing thread does not issue in the miss cycle.
  - If the other thread is not pending, `act_ctx` changes at the next edge. The other thread then issues in that very next cycle if it is ready.
- R3: A mispredict on the active thread suppresses its issue in that cycle. It switches the active context at the next edge when the other thread is not pending. When the other thread is pending, the context does not change. A mispredict never makes a thread pending.
- R4: While thread X runs and thread Y is pending, a completion for Y clears Y's pending state. It also makes Y active at the next edge.
- R5: When both threads are pending, the block enters idle. In idle, `idle` is 1, `issue` is 00, and `act_ctx` keeps the last active context.
- R6: On leaving idle, if both threads become free in the same cycle, the thread that was not last active is chosen. If only one thread becomes free, that thread is chosen.
- R7: With `dual_en` at 1, both issue bits are set in one cycle when all of the following hold:
  - the active thread issues;
  - the other thread is ready, not pending and not stalling;
  - the two class bits differ.
  Otherwise only the active thread can issue.
- R8: The read ports return the registers of the active context. A write goes to the context named by `wr_ctx`, whatever context is active. A read in the write cycle returns the old value, and the new value from the next cycle on.
- R9: A thread that is not ready does not issue. Lack of readiness is not a stall and causes no switch.
- R10: A miss and a completion for the same thread in one cycle leave that thread pending.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| th_rdy | input | 2 | Thread has an operation ready |
| th_cls | input | 2 | Class of that operation (0 integer, 1 floating point) |
| th_miss | input | 2 | Cache-miss pulse per thread |
| th_bpm | input | 2 | Branch-mispredict pulse per thread |
| th_done | input | 2 | Memory-completion pulse per thread |
| dual_en | input | 1 | Allow integer/floating-point pairing across threads |
| rd0_addr | input | 4 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 data, active context |
| rd1_addr | input | 4 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data, active context |
| wr_en | input | 1 | Register write enable |
| wr_ctx | input | 1 | Context that produced the result |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| act_ctx | output | 1 | Active context |
| issue | output | 2 | Per-thread issue grant this cycle |
| idle | output | 1 | Both threads pending, nothing issues |

## Verification

The checks assume three things about the stall sources:
- A miss is reported only by a thread that actually issued. That is the active thread, or the partner thread in a dual-issue cycle.
- A completion arrives only for a thread that is pending.
- No stall pulse arrives while the block is idle.

Under these assumptions the active context is never pending, and idle implies that both threads are pending. The stimulus table and the directed steps follow the same rules. Misses, mispredicts and completions are raised only on threads in those roles. The one case where a miss and a completion coincide is the deliberate R10 case, on a thread that is already pending.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;

    localparam int NTH = 2;

    typedef enum logic [1:0] {
        S_RUN_A = 2'd0,
        S_RUN_B = 2'd1,
        S_IDLE  = 2'd2
    } ctx_st_e;

    typedef logic [NTH-1:0] th_vec_t;

    function automatic ctx_st_e run_state(input logic t);
        return t ? S_RUN_B : S_RUN_A;
    endfunction

endpackage

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(NREGS)-1:0] ra0,
    input  logic [$clog2(NREGS)-1:0] ra1,
    output logic [DATA_W-1:0]        rd0,
    output logic [DATA_W-1:0]        rd1
);
    logic [DATA_W-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rd0 = regs_q[ra0];
        rd1 = regs_q[ra1];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[$past(waddr)] == $past(wdata))); // R8

endmodule

// File: rtl/ctx_stall_track.sv
module ctx_stall_track (
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    input  logic done,
    output logic pend_q,
    output logic pend_nx
);
    always_comb pend_nx = miss | (pend_q & ~done);

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_nx;
    end

    AST_MISS_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> pend_q); // R10

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !miss) |=> !pend_q); // R4

endmodule

// File: rtl/ctx_issue_fsm.sv
module ctx_issue_fsm
    import ctx_sel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  th_vec_t rdy,
    input  th_vec_t cls,
    input  th_vec_t miss,
    input  th_vec_t bpm,
    input  th_vec_t done,
    input  logic    dual_en,
    input  th_vec_t pend,
    input  th_vec_t pend_nx,
    output logic    act_o,
    output th_vec_t issue,
    output logic    idle_o
);
    ctx_st_e st_q, st_nx;
    logic    last_q;
    logic    cur;

    // current context as seen by the transition logic
    always_comb begin
        unique case (st_q)
            S_RUN_A: cur = 1'b0;
            S_RUN_B: cur = 1'b1;
            default: cur = last_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_RUN_A;
            last_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (st_q != S_IDLE) last_q <= cur;
        end
    end

    // transitions: switch, return, park, wake
    always_comb begin
        logic o;
        o     = ~cur;
        st_nx = st_q;
        unique case (st_q)
            S_RUN_A, S_RUN_B: begin
                if (pend_nx[cur] || bpm[cur]) begin
                    if (!pend_nx[o])      st_nx = run_state(o);
                    else if (pend_nx[cur]) st_nx = S_IDLE;
                end else if (done[o] && pend[o] && !pend_nx[o]) begin
                    st_nx = run_state(o);
                end
            end
            S_IDLE: begin
                if (!pend_nx[0] && !pend_nx[1]) st_nx = run_state(~last_q);
                else if (!pend_nx[0])          st_nx = S_RUN_A;
                else if (!pend_nx[1])          st_nx = S_RUN_B;
            end
            default: st_nx = S_RUN_A;
        endcase
    end

    // outputs
    always_comb begin
        logic a, o, ok_a, ok_o;
        a      = cur;
        o      = ~cur;
        idle_o = 1'b0;
        act_o  = cur;
        issue  = '0;
        ok_a   = 1'b0;
        ok_o   = 1'b0;
        unique case (st_q)
            S_RUN_A, S_RUN_B: begin
                ok_a = rdy[a] & ~pend[a] & ~miss[a] & ~bpm[a];
                ok_o = dual_en & ok_a & rdy[o] & ~pend[o] & ~miss[o] & ~bpm[o]
                       & (cls[o] != cls[a]);
                issue[a] = ok_a;
                issue[o] = ok_o;
            end
            S_IDLE:  idle_o = 1'b1;
            default: idle_o = 1'b0;
        endcase
    end

    AST_ACTIVE_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |-> !pend[cur]); // R2

    AST_SWITCH_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN_A && (miss[0] || bpm[0]) && !pend[1] && !miss[1])
        |=> (st_q == S_RUN_B)); // R3

    AST_IDLE_BOTH_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> (pend[0] && pend[1])); // R5

    AST_WAKE_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !last_q && !pend_nx[0] && !pend_nx[1])
        |=> (st_q == S_RUN_B)); // R6

endmodule

// File: rtl/thread_ctx_sel.sv
module thread_ctx_sel
    import ctx_sel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               th_rdy,
    input  logic [1:0]               th_cls,
    input  logic [1:0]               th_miss,
    input  logic [1:0]               th_bpm,
    input  logic [1:0]               th_done,
    input  logic                     dual_en,
    input  logic [$clog2(NREGS)-1:0] rd0_addr,
    output logic [DATA_W-1:0]        rd0_data,
    input  logic [$clog2(NREGS)-1:0] rd1_addr,
    output logic [DATA_W-1:0]        rd1_data,
    input  logic                     wr_en,
    input  logic                     wr_ctx,
    input  logic [$clog2(NREGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     act_ctx,
    output logic [1:0]               issue,
    output logic                     idle
);
    th_vec_t           pend, pend_nx;
    logic [DATA_W-1:0] rd0_c [NTH];
    logic [DATA_W-1:0] rd1_c [NTH];

    for (genvar t = 0; t < NTH; t++) begin : g_ctx
        ctx_stall_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .miss    (th_miss[t]),
            .done    (th_done[t]),
            .pend_q  (pend[t]),
            .pend_nx (pend_nx[t])
        );

        ctx_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_ctx == 1'(t))),
            .waddr (wr_addr),
            .wdata (wr_data),
            .ra0   (rd0_addr),
            .ra1   (rd1_addr),
            .rd0   (rd0_c[t]),
            .rd1   (rd1_c[t])
        );
    end

    ctx_issue_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy     (th_rdy),
        .cls     (th_cls),
        .miss    (th_miss),
        .bpm     (th_bpm),
        .done    (th_done),
        .dual_en (dual_en),
        .pend    (pend),
        .pend_nx (pend_nx),
        .act_o   (act_ctx),
        .issue   (issue),
        .idle_o  (idle)
    );

    always_comb begin
        rd0_data = rd0_c[act_ctx];
        rd1_data = rd1_c[act_ctx];
    end

    AST_PEND_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue & pend) == 2'b00); // R2

    AST_DUAL_NEEDS_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (issue == 2'b11) |-> (dual_en && th_cls[0] != th_cls[1])); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (issue == 2'b00)); // R5

endmodule

// File: tb/test_thread_ctx_sel.sv
module test_thread_ctx_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  th_rdy = '0, th_cls = '0, th_miss = '0, th_bpm = '0, th_done = '0;
    logic        dual_en = 1'b0;
    logic [3:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0, wr_ctx = 1'b0;
    logic        act_ctx, idle;
    logic [1:0]  issue;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    thread_ctx_sel i_thread_ctx_sel (
        .clk(clk), .rst_n(rst_n), .th_rdy(th_rdy), .th_cls(th_cls),
        .th_miss(th_miss), .th_bpm(th_bpm), .th_done(th_done), .dual_en(dual_en),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_data(wr_data),
        .act_ctx(act_ctx), .issue(issue), .idle(idle)
    );

    always #10 clk = ~clk;

    // {rdy, cls, miss, bpm, done, dual, exp_act, exp_issue, exp_idle}; bit 0 of each pair = A
    localparam int NV = 27;
    localparam logic [14:0] VEC [NV] = '{
        15'b11_00_00_00_00_0_0_01_0, // 0  R9 plain issue on A
        15'b11_00_01_00_00_0_0_00_0, // 1  R2 A misses
        15'b11_00_00_00_00_0_1_10_0, // 2  R2 B issues at once
        15'b11_01_00_00_00_1_1_10_0, // 3  R9 pending A cannot pair
        15'b11_00_00_00_01_0_1_10_0, // 4  R4 A completes
        15'b11_00_00_00_00_0_0_01_0, // 5  R4 A back
        15'b11_10_00_00_00_1_0_11_0, // 6  R7 int + fp pair
        15'b11_00_00_00_00_1_0_01_0, // 7  R7 same class
        15'b11_10_00_00_00_0_0_01_0, // 8  R7 dual off
        15'b11_00_00_01_00_0_0_00_0, // 9  R3 A mispredict
        15'b11_00_00_00_00_0_1_10_0, // 10 R3 B runs
        15'b11_00_10_00_00_0_1_00_0, // 11 R2 B misses
        15'b11_00_00_00_00_0_0_01_0, // 12 R2 A runs
        15'b11_00_00_01_00_0_0_00_0, // 13 R3 mispredict, B pending: stay
        15'b11_00_00_00_00_0_0_01_0, // 14 R3 still A
        15'b11_00_01_00_00_0_0_00_0, // 15 R5 A misses too
        15'b11_00_00_00_00_0_0_00_1, // 16 R5 idle
        15'b11_00_00_00_11_0_0_00_1, // 17 R6 both complete
        15'b11_00_00_00_00_0_1_10_0, // 18 R6 B chosen (A last)
        15'b11_00_10_00_00_0_1_00_0, // 19 R2 B misses
        15'b11_00_01_00_00_0_0_00_0, // 20 R5 A misses
        15'b11_00_00_00_10_0_0_00_1, // 21 R6 only B completes
        15'b11_00_00_00_00_0_1_10_0, // 22 R6 B chosen
        15'b11_00_01_00_01_0_1_10_0, // 23 R10 miss+done on A
        15'b11_00_00_00_00_0_1_10_0, // 24 R10 A still parked
        15'b11_00_00_00_01_0_1_10_0, // 25 R4 A completes
        15'b00_00_00_00_00_0_0_00_0  // 26 R9 nothing ready, no switch
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 2, 11, 12, 19:   return "R2";
            9, 10, 13, 14:      return "R3";
            4, 5, 25:           return "R4";
            15, 16, 20:         return "R5";
            17, 18, 21, 22:     return "R6";
            6, 7, 8:            return "R7";
            23, 24:             return "R10";
            default:            return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_in();
        th_rdy = '0; th_cls = '0; th_miss = '0; th_bpm = '0; th_done = '0;
        dual_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd0_addr = 4'd5; rd1_addr = 4'd15;
        #1;
        chk("R1 act", 32'(act_ctx), 32'd0);
        chk("R1 idle", 32'(idle), 32'd0);
        chk("R1 rd0", rd0_data, 32'd0);
        chk("R1 rd1", rd1_data, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {th_rdy, th_cls, th_miss, th_bpm, th_done, dual_en} = VEC[i][14:4];
            #1;
            chk({vec_tag(i), " act"},   32'(act_ctx), 32'(VEC[i][3]));
            chk({vec_tag(i), " issue"}, 32'(issue),   32'(VEC[i][2:1]));
            chk({vec_tag(i), " idle"},  32'(idle),    32'(VEC[i][0]));
        end

        // R8: write into A while A active, read-during-write returns old data
        @(negedge clk);
        clear_in();
        wr_en = 1'b1; wr_ctx = 1'b0; wr_addr = 4'd3; wr_data = 32'hA5A5_0001;
        rd0_addr = 4'd3; rd1_addr = 4'd3;
        #1;
        chk("R8 old value", rd0_data, 32'd0);
        @(negedge clk);
        wr_ctx = 1'b1; wr_data = 32'h0000_B002;
        #1;
        chk("R8 new value A", rd0_data, 32'hA5A5_0001);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R8 B write hidden rd0", rd0_data, 32'hA5A5_0001);
        chk("R8 B write hidden rd1", rd1_data, 32'hA5A5_0001);
        // switch to B by a miss on A, then read B's copy
        @(negedge clk);
        th_miss = 2'b01;
        @(negedge clk);
        th_miss = 2'b00;
        #1;
        chk("R2 act after miss", 32'(act_ctx), 32'd1);
        chk("R8 B copy", rd0_data, 32'h0000_B002);
        // write to A while B active, then return to A
        @(negedge clk);
        wr_en = 1'b1; wr_ctx = 1'b0; wr_addr = 4'd7; wr_data = 32'h1234_5678;
        th_done = 2'b01;
        @(negedge clk);
        clear_in();
        rd0_addr = 4'd7;
        #1;
        chk("R4 act after done", 32'(act_ctx), 32'd0);
        chk("R8 write to inactive ctx", rd0_data, 32'h1234_5678);

        // R1: reset in mid-run clears both contexts
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd0_addr = 4'd3; rd1_addr = 4'd7;
        #1;
        chk("R1 rd0 after reset", rd0_data, 32'd0);
        chk("R1 rd1 after reset", rd1_data, 32'd0);
        chk("R1 act after reset", 32'(act_ctx), 32'd0);
        @(negedge clk);
        th_miss = 2'b01;
        @(negedge clk);
        th_miss = 2'b00;
        #1;
        chk("R1 B copy cleared", rd0_data, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule